// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block links two 8-bit buses, called A and B, and can move data in either direction. Each direction has its own capture register with its own clock. The A-to-B register takes the A bus on every rising edge of `clk_ab`. The B-to-A register takes the B bus on every rising edge of `clk_ba`. Both registers capture whatever the output controls are set to.

The active-low enable `oe_n` and the `dir` input decide which bus, if either, the block drives:
- With `oe_n` high, neither bus is driven.
- With `oe_n` low and `dir` low, the A bus is driven.
- With `oe_n` low and `dir` high, the B bus is driven.

The select input for the active direction then picks the value on the driven bus. Low selects the live value from the opposite bus. High selects the value stored in that direction's register.

Each tristate pin is split into an input vector, an output vector and one output-enable bit. While an output-enable bit is low, the value on the matching output vector has no meaning. The data pins carry no valid/ready handshake because they are plain levels, with no items to accept or hold back. All pins are plain controls and data.

Top module: `xcvr_regbus`

## Requirements
- R1: The active-low asynchronous reset `rst_n` clears both capture registers to 0x00. After reset, each stored path drives 0x00 until its register first captures.
- R2: On every rising edge of `clk_ab`, the A-to-B register loads `a_in`, whatever the values of `oe_n`, `dir` and the selects.
- R3: On every rising edge of `clk_ba`, the B-to-A register loads `b_in`, whatever the values of `oe_n`, `dir` and the selects.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R5: With `oe_n`=0 and `dir`=0, `a_oe`=1 and `b_oe`=0. When `sel_ba`=0, `a_out` equals `b_in` in the same cycle, with no clock edge needed.
- R6: With `oe_n`=0, `dir`=0 and `sel_ba`=1, `a_out` equals the B-to-A register.
- R7: With `oe_n`=0 and `dir`=1, `b_oe`=1 and `a_oe`=0. When `sel_ab`=0, `b_out` equals `a_in` in the same cycle.
- R8: With `oe_n`=0, `dir`=1 and `sel_ab`=1, `b_out` equals the A-to-B register.
- R9: The two registers are independent. An edge on `clk_ab` leaves the B-to-A register unchanged, and an edge on `clk_ba` leaves the A-to-B register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe_n | input | 1 | Output enable shared by both buses, active low |
| dir | input | 1 | Drive direction: 0 drives A, 1 drives B |
| sel_ab | input | 1 | B-bus source: 0 selects live A, 1 selects the stored A |
| sel_ba | input | 1 | A-bus source: 0 selects live B, 1 selects the stored B |
| a_in | input | 8 | Value seen on the A bus |
| a_out | output | 8 | Value offered to the A bus |
| a_oe | output | 1 | A bus driven when 1 |
| b_in | input | 8 | Value seen on the B bus |
| b_out | output | 8 | Value offered to the B bus |
| b_oe | output | 1 | B bus driven when 1 |

## Verification
Live-path values and the output enables are combinational, so they are due in the same cycle as the input change. A stored value is due after exactly one rising edge of its own clock. The bench changes inputs and gates each clock only on falling edges of the base clock, so each capture edge is a single, known edge. It then samples 1 ns after the falling edge, when every result is due and no edge is near. The bound checker compares each stored output with the bus value sampled at the previous edge of the same clock. It makes that comparison only once such an edge has occurred since reset.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_DATA_W = 8;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } xcvr_drive_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Captures on every rising edge; no enable gates the load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int unsigned W = 8
) (
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  always_comb begin
    y = use_stored ? stored : live;
  end
endmodule

// File: rtl/xcvr_drive_decode.sv
module xcvr_drive_decode
  import xcvr_pkg::*;
(
  input  logic        oe_n,
  input  logic        dir,
  output xcvr_drive_e drive,
  output logic        a_oe,
  output logic        b_oe
);
  always_comb begin
    if (oe_n)     drive = DRV_NONE;
    else if (dir) drive = DRV_B;
    else          drive = DRV_A;
    a_oe = (drive == DRV_A);
    b_oe = (drive == DRV_B);
  end
endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_DATA_W
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] reg_ab;
  logic [W-1:0] reg_ba;
  xcvr_drive_e  drive;

  // A-side sample, launched towards B
  xcvr_capture_reg #(.W(W)) u_reg_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(reg_ab)
  );

  // B-side sample, launched towards A
  xcvr_capture_reg #(.W(W)) u_reg_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(reg_ba)
  );

  xcvr_path_mux #(.W(W)) u_mux_to_b (
    .use_stored(sel_ab), .live(a_in), .stored(reg_ab), .y(b_out)
  );

  xcvr_path_mux #(.W(W)) u_mux_to_a (
    .use_stored(sel_ba), .live(b_in), .stored(reg_ba), .y(a_out)
  );

  xcvr_drive_decode u_decode (
    .oe_n(oe_n), .dir(dir), .drive(drive), .a_oe(a_oe), .b_oe(b_oe)
  );
endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst_n,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  // Set once an edge of each clock has occurred since reset, so that $past is meaningful.
  logic ab_primed;
  logic ba_primed;

  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n) ab_primed <= 1'b0;
    else        ab_primed <= 1'b1;
  end

  always_ff @(posedge clk_ba or negedge rst_n) begin
    if (!rst_n) ba_primed <= 1'b0;
    else        ba_primed <= 1'b1;
  end

  p_isolated_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));

  p_drive_a_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && !dir) |-> (a_oe && !b_oe));

  p_drive_b_r7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir) |-> (b_oe && !a_oe));

  p_live_to_a_r5: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir && !sel_ba) |-> (a_out == b_in));

  p_live_to_b_r7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir && !sel_ab) |-> (b_out == a_in));

  p_stored_to_b_r2_r8: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (ab_primed && !oe_n && dir && sel_ab) |-> (b_out == $past(a_in)));

  p_stored_to_a_r3_r6: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (ba_primed && !oe_n && !dir && sel_ba) |-> (a_out == $past(b_in)));
endmodule

bind xcvr_regbus xcvr_regbus_chk #(.W(W)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/xcvr_regbus_tb.sv
module xcvr_regbus_tb;
  localparam int W = 8;

  typedef struct {
    string        req;
    logic         a_oe;
    logic         b_oe;
    logic         chk_a;
    logic [W-1:0] a_out;
    logic         chk_b;
    logic [W-1:0] b_out;
  } item_t;

  logic clk = 1'b0;
  logic gate_ab = 1'b0;
  logic gate_ba = 1'b0;
  logic clk_ab, clk_ba;
  logic rst_n = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #2.5 clk = ~clk;
  assign clk_ab = clk & gate_ab;
  assign clk_ba = clk & gate_ba;

  xcvr_regbus #(.W(W)) u_dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // Driver side: queue an expectation 1 ns after the falling edge.
  task automatic expect_out(input string req, input logic eao, input logic ebo,
                            input logic ca, input logic [W-1:0] ea,
                            input logic cb, input logic [W-1:0] eb);
    item_t it;
    #1;
    it.req = req; it.a_oe = eao; it.b_oe = ebo;
    it.chk_a = ca; it.a_out = ea; it.chk_b = cb; it.b_out = eb;
    sb.push_back(it);
    #0.5;
  endtask

  task automatic set_ctl(input logic n, input logic d, input logic sab, input logic sba);
    @(negedge clk);
    oe_n = n; dir = d; sel_ab = sab; sel_ba = sba;
  endtask

  // One gated rising edge of clk_ab capturing v.
  task automatic pulse_ab(input logic [W-1:0] v);
    @(negedge clk); a_in = v; gate_ab = 1'b1;
    @(negedge clk); gate_ab = 1'b0;
  endtask

  task automatic pulse_ba(input logic [W-1:0] v);
    @(negedge clk); b_in = v; gate_ba = 1'b1;
    @(negedge clk); gate_ba = 1'b0;
  endtask

  // Monitor: pop expectations and compare against the ports.
  initial begin
    forever begin
      wait (sb.size() > 0);
      begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (a_oe !== it.a_oe || b_oe !== it.b_oe) begin
          errors++;
          $display("FAIL %s oe a=%b b=%b expected a=%b b=%b", it.req, a_oe, b_oe, it.a_oe, it.b_oe);
        end else if (it.chk_a && a_out !== it.a_out) begin
          errors++;
          $display("FAIL %s a_out=%h expected %h", it.req, a_out, it.a_out);
        end else if (it.chk_b && b_out !== it.b_out) begin
          errors++;
          $display("FAIL %s b_out=%h expected %h", it.req, b_out, it.b_out);
        end
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4 during reset, outputs isolated
    @(negedge clk);
    expect_out("R4", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
    @(negedge clk); rst_n = 1'b1;
    // R1 stored paths read zero after reset
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0); a_in = 8'hEE;
    expect_out("R1", 1'b0, 1'b1, 1'b0, '0, 1'b1, 8'h00);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1); b_in = 8'hDD;
    expect_out("R1", 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, '0);
    // R7 live A to B
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0); a_in = 8'h5A;
    expect_out("R7", 1'b0, 1'b1, 1'b0, '0, 1'b1, 8'h5A);
    @(negedge clk); a_in = 8'hC3;
    expect_out("R7", 1'b0, 1'b1, 1'b0, '0, 1'b1, 8'hC3);
    // R2 / R8 stored A to B
    pulse_ab(8'h3C);
    @(negedge clk); a_in = 8'hFF; sel_ab = 1'b1;
    expect_out("R8", 1'b0, 1'b1, 1'b0, '0, 1'b1, 8'h3C);
    // R5 live B to A
    set_ctl(1'b0, 1'b0, 1'b1, 1'b0); b_in = 8'h81;
    expect_out("R5", 1'b1, 1'b0, 1'b1, 8'h81, 1'b0, '0);
    // R3 / R6 stored B to A
    pulse_ba(8'h7E);
    @(negedge clk); b_in = 8'h00; sel_ba = 1'b1;
    expect_out("R6", 1'b1, 1'b0, 1'b1, 8'h7E, 1'b0, '0);
    // R9 independence of the two registers
    pulse_ab(8'h11);
    expect_out("R9", 1'b1, 1'b0, 1'b1, 8'h7E, 1'b0, '0);
    pulse_ba(8'h22);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_out("R9", 1'b0, 1'b1, 1'b0, '0, 1'b1, 8'h11);
    // R4 isolation while both registers keep capturing
    set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
    expect_out("R4", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
    pulse_ab(8'hA5);
    pulse_ba(8'h5A);
    expect_out("R4", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_out("R2", 1'b0, 1'b1, 1'b0, '0, 1'b1, 8'hA5);
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    expect_out("R3", 1'b1, 1'b0, 1'b1, 8'h5A, 1'b0, '0);
    // R1 mid-run asynchronous reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_out("R1", 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, '0);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_out("R1", 1'b0, 1'b1, 1'b0, '0, 1'b1, 8'h00);
    repeat (3) @(negedge clk);
    wait (sb.size() == 0);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule